// File: doc/BRIEF.md
# Power-Management Bus Command Channel

This block is a single software command channel that a processor drives through a small memory-mapped register window in order to read or write registers in a slave on a power-management serial bus. Software loads the data to send into a write-data register, then writes one packed command word that selects the access type, the direction, the slave, the byte count and the register address. If the channel is idle, it latches the command and presents it as a request to the downstream serial bus master. It holds that request until the master accepts it.

A write finishes as soon as the master accepts it. A read also captures the data the master returns in the same handshake. The channel then parks in a wait state with that data readable, and stays there until software writes a 1 to a separate valid-clear register. A command written while the channel is occupied is thrown away, and a sticky error flag records the drop. The serial master itself is outside this block.

The downstream request is a valid/ready stream with these back-pressure rules:
- `dn_valid` stays high and every request field stays constant until a cycle in which `dn_ready` is high.
- `dn_ready` has no effect while `dn_valid` is low.
- `dn_rdata` is sampled only in the handshake cycle of a read.

Top module: `pwrbus_cmd_chan`

## Requirements
- R1: After reset the status register reads 0 (idle, no error), the read-data and command registers read 0, and `dn_valid` is low.
- R2: Register window offsets:
  - 0x00 is the command register; it reads back the latched command with bits 28 and 23:18 as zero.
  - 0x04 is write data and reads back what was written.
  - 0x14 is read data.
  - 0x24 is valid-clear, which reads as zero.
  - 0x28 is status.
  - Any other offset reads as zero.
- R3: A write to 0x00 while idle is accepted. From the next cycle `dn_valid` is high and status bits [3:1] read 1. The request carries these fields of the command word:
  - bits [31:30]: type, passed through unchanged (0 register-zero write, 1 register, 2 extended, 3 extended-long).
  - bit 29: direction, 1 for write and 0 for read.
  - bits [27:24]: slave ID.
  - bits [17:16]: byte count minus one.
  - bits [15:0]: register address.
- R4: While `dn_valid` is high and `dn_ready` is low, the request stays asserted with every field unchanged. `dn_ready` pulsed while no request is pending changes nothing.
- R5: For a write, `dn_wdata` is the write-data register as it was when the command was accepted. Only the count+1 low bytes are kept (byte 0 in bits [7:0]) and the rest are zero. Later writes to 0x04 do not alter it.
- R6: A write request returns the channel to idle (status state 0) in the cycle after its handshake.
- R7: A read handshake stores `dn_rdata` into 0x14, keeping only the count+1 low bytes and zeroing the others. It moves the channel to state 6, so status reads 0xC when no error is set.
- R8: State 6 persists until a write to 0x24 with bit 0 set, which returns the channel to idle. A write to 0x24 with bit 0 clear has no effect.
- R9: A command written while the channel is not idle is dropped: the pending request and the latched command are unchanged, and status bit 0 sets. Writing 0x24 with bit 0 set clears status bit 0 in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register window byte offset |
| reg_we | input | 1 | Register write strobe, single cycle |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, same cycle |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted (acknowledge) |
| dn_kind | output | 2 | Access type |
| dn_write | output | 1 | 1 write, 0 read |
| dn_sid | output | 4 | Slave ID |
| dn_cnt | output | 2 | Byte count minus one |
| dn_addr | output | 16 | Slave register address |
| dn_wdata | output | 32 | Write data, byte-masked (meaningful for writes) |
| dn_rdata | input | 32 | Read data returned with the read handshake |

## Verification
The hardest situations to reach from the ports are these:
- a second command, or a write-data update, arriving while a request is stalled by back-pressure;
- a valid-clear written with bit 0 low while a read result is parked.

The randomized loop holds `dn_ready` low for a random number of cycles. In a share of the iterations it injects a conflicting command word and a new write-data value during that stall. It then checks that the request fields, the write data and the latched command did not move, and that the error flag set and then clears. Directed cases cover the byte-count extremes (one byte against all-ones return data, and four bytes).

// File: rtl/pwrbus_chan_pkg.sv
package pwrbus_chan_pkg;

  localparam int DATA_W = 32;
  localparam int NBYTES = DATA_W / 8;

  // register window byte offsets
  localparam logic [7:0] OFS_CMD   = 8'h00;
  localparam logic [7:0] OFS_WDATA = 8'h04;
  localparam logic [7:0] OFS_RDATA = 8'h14;
  localparam logic [7:0] OFS_CLR   = 8'h24;
  localparam logic [7:0] OFS_STAT  = 8'h28;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BUSY = 3'd1,
    ST_WCLR = 3'd6
  } chan_state_e;

  typedef struct packed {
    logic [1:0]  kind;
    logic        write;
    logic [3:0]  sid;
    logic [1:0]  cnt;
    logic [15:0] addr;
  } chan_cmd_t;

  function automatic chan_cmd_t unpack_cmd(input logic [31:0] w);
    chan_cmd_t c;
    c.kind  = w[31:30];
    c.write = w[29];
    c.sid   = w[27:24];
    c.cnt   = w[17:16];
    c.addr  = w[15:0];
    return c;
  endfunction

  function automatic logic [31:0] pack_cmd(input chan_cmd_t c);
    return {c.kind, c.write, 1'b0, c.sid, 6'b0, c.cnt, c.addr};
  endfunction

endpackage

// File: rtl/chan_bytemask.sv
module chan_bytemask #(
  parameter int NBYTES = 4,
  localparam int CW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic [8*NBYTES-1:0] din,
  input  logic [CW-1:0]       cnt,
  output logic [8*NBYTES-1:0] dout
);
  // keep bytes 0..cnt, zero the rest
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign dout[8*b +: 8] = (CW'(b) <= cnt) ? din[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/chan_regwin.sv
module chan_regwin
  import pwrbus_chan_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] cmd_word,
  input  logic [DATA_W-1:0] rdata_q,
  input  chan_state_e       state,
  input  logic              err,
  output logic [DATA_W-1:0] wdata_q,
  output logic              cmd_wr,
  output logic              clr_wr
);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_WDATA = ADDR_W'(OFS_WDATA);
  localparam logic [ADDR_W-1:0] A_RDATA = ADDR_W'(OFS_RDATA);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);

  assign cmd_wr = reg_we && (reg_addr == A_CMD);
  assign clr_wr = reg_we && (reg_addr == A_CLR) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdata_q <= '0;
    else if (reg_we && (reg_addr == A_WDATA)) wdata_q <= reg_wdata;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CMD:   reg_rdata = cmd_word;
      A_WDATA: reg_rdata = wdata_q;
      A_RDATA: reg_rdata = rdata_q;
      A_STAT:  reg_rdata = {{(DATA_W-4){1'b0}}, state, err};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/chan_fsm.sv
module chan_fsm
  import pwrbus_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_in,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic              dn_ready,
  input  logic [DATA_W-1:0] dn_rdata,
  output chan_state_e       state,
  output logic              err,
  output chan_cmd_t         cmd_q,
  output logic [DATA_W-1:0] wsnap,
  output logic [DATA_W-1:0] rdata_q,
  output logic              dn_valid
);
  chan_cmd_t         cmd_new;
  logic [DATA_W-1:0] wdata_m, rdata_m;
  logic              hs;

  assign cmd_new  = unpack_cmd(cmd_in);
  assign dn_valid = (state == ST_BUSY);
  assign hs       = dn_valid && dn_ready;

  chan_bytemask #(.NBYTES(NBYTES)) u_wmask (.din(wdata_q),  .cnt(cmd_new.cnt), .dout(wdata_m));
  chan_bytemask #(.NBYTES(NBYTES)) u_rmask (.din(dn_rdata), .cnt(cmd_q.cnt),   .dout(rdata_m));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      err     <= 1'b0;
      cmd_q   <= '0;
      wsnap   <= '0;
      rdata_q <= '0;
    end else begin
      if (cmd_wr && state == ST_IDLE) begin
        cmd_q <= cmd_new;
        wsnap <= wdata_m;
      end
      if (clr_wr) err <= 1'b0;
      else if (cmd_wr && state != ST_IDLE) err <= 1'b1;
      unique case (state)
        ST_IDLE: if (cmd_wr) state <= ST_BUSY;
        ST_BUSY: if (hs) begin
          if (cmd_q.write) state <= ST_IDLE;
          else begin
            rdata_q <= rdata_m;
            state   <= ST_WCLR;
          end
        end
        ST_WCLR: if (clr_wr) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state inside {ST_IDLE, ST_BUSY, ST_WCLR});  // R3
  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && state == ST_IDLE) |=> dn_valid);  // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(cmd_q) && $stable(wsnap)));  // R4
  AST_WR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && cmd_q.write) |=> (state == ST_IDLE));  // R6
  AST_RD_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !cmd_q.write) |=> (state == ST_WCLR));  // R7
  AST_WCLR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WCLR && !clr_wr) |=> (state == ST_WCLR && $stable(rdata_q)));  // R8
  AST_DROP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !clr_wr && state != ST_IDLE) |=> (err && $stable(cmd_q)));  // R9
endmodule

// File: rtl/pwrbus_cmd_chan.sv
module pwrbus_cmd_chan
  import pwrbus_chan_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [1:0]        dn_kind,
  output logic              dn_write,
  output logic [3:0]        dn_sid,
  output logic [1:0]        dn_cnt,
  output logic [15:0]       dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic [31:0]       dn_rdata
);
  chan_state_e       state;
  chan_cmd_t         cmd_q;
  logic              err, cmd_wr, clr_wr;
  logic [DATA_W-1:0] wdata_q, rdata_q, wsnap;

  chan_regwin #(.ADDR_W(ADDR_W)) u_win (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_word(pack_cmd(cmd_q)), .rdata_q(rdata_q), .state(state), .err(err),
    .wdata_q(wdata_q), .cmd_wr(cmd_wr), .clr_wr(clr_wr)
  );

  chan_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_in(reg_wdata), .clr_wr(clr_wr), .wdata_q(wdata_q),
    .dn_ready(dn_ready), .dn_rdata(dn_rdata),
    .state(state), .err(err), .cmd_q(cmd_q), .wsnap(wsnap), .rdata_q(rdata_q),
    .dn_valid(dn_valid)
  );

  assign dn_kind  = cmd_q.kind;
  assign dn_write = cmd_q.write;
  assign dn_sid   = cmd_q.sid;
  assign dn_cnt   = cmd_q.cnt;
  assign dn_addr  = cmd_q.addr;
  assign dn_wdata = wsnap;
endmodule

// File: tb/sim_pwrbus_cmd_chan.sv
module sim_pwrbus_cmd_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dn_valid, dn_write;
  logic        dn_ready = 1'b0;
  logic [1:0]  dn_kind, dn_cnt;
  logic [3:0]  dn_sid;
  logic [15:0] dn_addr;
  logic [31:0] dn_wdata;
  logic [31:0] dn_rdata = '0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwrbus_cmd_chan #(.ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dn_valid(dn_valid),
    .dn_ready(dn_ready), .dn_kind(dn_kind), .dn_write(dn_write), .dn_sid(dn_sid),
    .dn_cnt(dn_cnt), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
  );

  function automatic logic [31:0] exp_mask(input logic [1:0] cnt);
    logic [39:0] t;
    t = (40'h1 << (8 * (int'(cnt) + 1))) - 40'h1;
    return t[31:0];
  endfunction

  function automatic logic [31:0] exp_status(input logic [2:0] st, input logic e);
    return {28'b0, st, e};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic ack(input logic [31:0] d);
    @(negedge clk);
    dn_rdata = d; dn_ready = 1'b1;
    @(negedge clk);
    dn_ready = 1'b0;
  endtask

  // one full transaction, with optional stall disturbances
  task automatic run_txn(input logic [1:0] kind, input logic wr, input logic [3:0] sid,
                         input logic [1:0] cnt, input logic [15:0] addr,
                         input logic [31:0] wd, input logic [31:0] rd,
                         input int waits, input bit disturb);
    logic [31:0] cmd, v, junk;
    junk = $urandom;
    cmd = {kind, wr, junk[0], sid, junk[6:1], cnt, addr};
    bus_wr(8'h04, wd);
    bus_wr(8'h00, cmd);
    check("R3", "dn_valid", {31'b0, dn_valid}, 32'd1);
    check("R3", "fields", {dn_kind, dn_write, dn_sid, dn_cnt, dn_addr},
          {kind, wr, sid, cnt, addr});
    bus_rd(8'h28, v); check("R3", "status busy", v, exp_status(3'd1, 1'b0));
    bus_rd(8'h00, v); check("R2", "cmd readback", v, cmd & 32'hEF03FFFF);
    if (wr) check("R5", "dn_wdata", dn_wdata, wd & exp_mask(cnt));
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      check("R4", "stall fields", {dn_valid, dn_kind, dn_write, dn_sid, dn_cnt, dn_addr},
            {1'b1, kind, wr, sid, cnt, addr});
    end
    if (disturb) begin
      bus_wr(8'h04, ~wd);
      bus_wr(8'h00, ~cmd);
      bus_rd(8'h28, v); check("R9", "err set", v, exp_status(3'd1, 1'b1));
      check("R9", "fields kept", {dn_valid, dn_kind, dn_write, dn_sid, dn_cnt, dn_addr},
            {1'b1, kind, wr, sid, cnt, addr});
      bus_rd(8'h00, v); check("R9", "cmd kept", v, cmd & 32'hEF03FFFF);
      if (wr) check("R5", "wdata snapshot", dn_wdata, wd & exp_mask(cnt));
      bus_wr(8'h24, 32'h1);
      bus_rd(8'h28, v); check("R9", "err clear in busy", v, exp_status(3'd1, 1'b0));
    end
    ack(rd);
    if (wr) begin
      bus_rd(8'h28, v); check("R6", "idle after write", v, exp_status(3'd0, 1'b0));
    end else begin
      bus_rd(8'h28, v); check("R7", "status wclr", v, exp_status(3'd6, 1'b0));
      bus_rd(8'h14, v); check("R7", "rdata masked", v, rd & exp_mask(cnt));
      bus_wr(8'h24, 32'hFFFF_FFFE);
      bus_rd(8'h28, v); check("R8", "clear bit0=0 ignored", v, exp_status(3'd6, 1'b0));
      bus_wr(8'h24, 32'h1);
      bus_rd(8'h28, v); check("R8", "idle after clear", v, exp_status(3'd0, 1'b0));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    bus_rd(8'h28, v); check("R1", "status", v, 32'd0);
    bus_rd(8'h14, v); check("R1", "rdata", v, 32'd0);
    bus_rd(8'h00, v); check("R1", "cmd", v, 32'd0);
    check("R1", "dn_valid", {31'b0, dn_valid}, 32'd0);
    // R2 window decode
    bus_wr(8'h04, 32'hA5A5_1234);
    bus_rd(8'h04, v); check("R2", "wdata readback", v, 32'hA5A5_1234);
    bus_rd(8'h08, v); check("R2", "unmapped", v, 32'd0);
    bus_rd(8'hFC, v); check("R2", "unmapped high", v, 32'd0);
    bus_wr(8'h24, 32'h1);
    bus_rd(8'h24, v); check("R2", "clear reads zero", v, 32'd0);
    // R4 ready while idle is ignored
    ack(32'hDEAD_BEEF);
    bus_rd(8'h28, v); check("R4", "ready idle ignored", v, 32'd0);
    bus_rd(8'h14, v); check("R4", "rdata untouched", v, 32'd0);
    // directed byte-count extremes
    run_txn(2'd1, 1'b0, 4'hF, 2'd0, 16'hFFFF, 32'h0, 32'hFFFF_FFFF, 2, 1'b0);
    run_txn(2'd3, 1'b0, 4'h0, 2'd3, 16'h0000, 32'h0, 32'h8765_4321, 0, 1'b1);
    run_txn(2'd0, 1'b1, 4'h5, 2'd3, 16'h1234, 32'hCAFE_F00D, 32'h0, 1, 1'b1);
    run_txn(2'd2, 1'b1, 4'h9, 2'd0, 16'h00AA, 32'hFFFF_FFFF, 32'h0, 0, 1'b0);
    // constrained random
    for (int k = 0; k < 60; k++) begin
      run_txn(2'($urandom % 4), 1'($urandom % 2), 4'($urandom), 2'($urandom),
              16'($urandom), $urandom, $urandom, int'($urandom % 4), ($urandom % 4) == 0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule